// File: doc/BRIEF.md
# Dual-Core Interrupt and Event Glue

This block is the combinational wiring that sits between a two-core processor cluster, its interrupt controller and the baseboard. For each core it builds the active-low IRQ and FIQ inputs. Each one merges an active-low board interrupt, a software-forced interrupt bit and the active-low outputs of a set of vectored interrupt controllers.

It also packs the system's peripheral interrupt sources into one wide shared-interrupt vector for the interrupt controller. The performance-monitor sources arrive active low and are inverted on the way in.

The cores do not pass wait-for-event signals to each other internally, so the block routes them across. Each core's event input combines the board event, the other core's event output and a split/lock wakeup pulse. The board also receives an event output that combines both cores' event outputs.

There is no clock, no register and no handshake. Every output is a pure function of the current inputs. All pins are plain level signals, and any synchronisation is done upstream.

Top module: `dual_core_int_glue`

## Requirements
- R1: Each core's active-low IRQ output equals board_nirq_i AND NOT sw_irq_i AND every bit of vec_nirq_i. Both cores always see the same value.
- R2: Each core's active-low FIQ output equals board_nfiq_i AND NOT sw_fiq_i AND every bit of vec_nfiq_i. Both cores always see the same value.
- R3: core_evti_o[0] is board_evt_i OR core_evto_i[1] OR sl_wake_i. core_evti_o[1] is board_evt_i OR core_evto_i[0] OR sl_wake_i. A core's own event output never reaches its own event input.
- R4: board_evt_o is the OR of core_evto_i[0] and core_evto_i[1].
- R5: Bits 42:0 of spi_vec_o equal board_spi_i bit for bit.
- R6: In spi_vec_o, bit 44 is lcd_irq_i, bit 45 is smem_irq_i[0] and bit 46 is smem_irq_i[1]. Bit 52 is dma_abort_i, bit 54 is dma_irq_i[0] and bit 55 is dma_irq_i[1].
- R7: In spi_vec_o, bits 60 and 61 are the inverses of core_npmu_i[0] and core_npmu_i[1]. Bits 64, 65, 66 and 67 are comm_rx_i[0], comm_rx_i[1], comm_tx_i[0] and comm_tx_i[1].
- R8: Every other bit of spi_vec_o is always 0. That covers bit 43, bits 47 to 51, bit 53, bits 56 to 59, bits 62 and 63, and bits 127:68.
- R9: All outputs follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| board_nirq_i | input | 1 | Board IRQ, active low |
| board_nfiq_i | input | 1 | Board FIQ, active low |
| sw_irq_i | input | 1 | Software-forced IRQ, active high |
| sw_fiq_i | input | 1 | Software-forced FIQ, active high |
| vec_nirq_i | input | 2 | Vectored controller IRQ outputs, active low |
| vec_nfiq_i | input | 2 | Vectored controller FIQ outputs, active low |
| core_evto_i | input | 2 | Per-core event outputs |
| board_evt_i | input | 1 | Board event to the cores |
| sl_wake_i | input | 1 | Split/lock sequencer wakeup |
| board_spi_i | input | 43 | Board interrupt lines |
| lcd_irq_i | input | 1 | Display controller interrupt |
| smem_irq_i | input | 2 | Static memory controller interrupts |
| dma_abort_i | input | 1 | DMA abort interrupt |
| dma_irq_i | input | 2 | DMA channel interrupts |
| core_npmu_i | input | 2 | Per-core performance-monitor interrupts, active low |
| comm_rx_i | input | 2 | Per-core debug comms receive |
| comm_tx_i | input | 2 | Per-core debug comms transmit |
| core_nirq_o | output | 2 | Per-core IRQ, active low |
| core_nfiq_o | output | 2 | Per-core FIQ, active low |
| core_evti_o | output | 2 | Per-core event inputs |
| board_evt_o | output | 1 | Event output to the board |
| spi_vec_o | output | 128 | Shared-interrupt vector |

## Verification
The assertions are immediate checks that run whenever a combinational value settles. They assume that every input has a known 0 or 1 level. They also assume that the software-force bits act as overrides that dominate every other IRQ or FIQ source.

The bench drives each input from a variable that is initialised at declaration, so no unknown value ever reaches the block. It then applies only full 0/1 patterns, either from a fixed-seed $urandom stream or from directed corner cases. It checks each pattern after a short settle delay and without waiting for a clock edge.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int unsigned SPI_W       = 128;
  localparam int unsigned BOARD_LINES = 43;
  localparam int unsigned N_CORES     = 2;
  localparam int unsigned N_VEC       = 2;

  localparam int unsigned POS_LCD     = 44;
  localparam int unsigned POS_SMEM0   = 45;
  localparam int unsigned POS_SMEM1   = 46;
  localparam int unsigned POS_DMA_AB  = 52;
  localparam int unsigned POS_DMA0    = 54;
  localparam int unsigned POS_DMA1    = 55;
  localparam int unsigned POS_PMU0    = 60;
  localparam int unsigned POS_PMU1    = 61;
  localparam int unsigned POS_COMM    = 64;  // rx0, rx1, tx0, tx1 in ascending bits

  function automatic logic [SPI_W-1:0] used_mask();
    logic [SPI_W-1:0] m;
    m = '0;
    for (int i = 0; i < int'(BOARD_LINES); i++) m[i] = 1'b1;
    m[POS_LCD] = 1'b1;
    m[POS_SMEM0] = 1'b1;
    m[POS_SMEM1] = 1'b1;
    m[POS_DMA_AB] = 1'b1;
    m[POS_DMA0] = 1'b1;
    m[POS_DMA1] = 1'b1;
    m[POS_PMU0] = 1'b1;
    m[POS_PMU1] = 1'b1;
    for (int i = 0; i < 4; i++) m[POS_COMM+i] = 1'b1;
    return m;
  endfunction

  localparam logic [SPI_W-1:0] SPI_USED = used_mask();
endpackage

// File: rtl/int_line_merge.sv
module int_line_merge #(
  parameter int unsigned NVEC = 2
) (
  input  logic            board_n_i,
  input  logic            sw_force_i,
  input  logic [NVEC-1:0] vec_n_i,
  output logic            line_n_o
);
  logic vec_all_idle;

  always_comb begin
    vec_all_idle = 1'b1;
    for (int i = 0; i < int'(NVEC); i++) vec_all_idle = vec_all_idle & vec_n_i[i];
  end

  assign line_n_o = board_n_i & ~sw_force_i & vec_all_idle;

  // Serves R1 (IRQ instance) and R2 (FIQ instance): a software force always wins.
  always_comb begin
    if (sw_force_i) assert_force_dominates_R1: assert (line_n_o == 1'b0);
  end
endmodule

// File: rtl/event_xlink.sv
module event_xlink #(
  parameter int unsigned NCORE = 2
) (
  input  logic             board_evt_i,
  input  logic             wake_i,
  input  logic [NCORE-1:0] evto_i,
  output logic [NCORE-1:0] evti_o,
  output logic             board_evt_o
);
  for (genvar k = 0; k < NCORE; k++) begin : g_core
    logic peers;
    always_comb begin
      peers = 1'b0;
      for (int j = 0; j < int'(NCORE); j++)
        if (j != k) peers = peers | evto_i[j];
    end
    assign evti_o[k] = board_evt_i | peers | wake_i;
  end

  assign board_evt_o = |evto_i;

  always_comb begin
    if (wake_i) assert_wake_reaches_all_R3: assert (&evti_o);
    if (board_evt_o) assert_evt_out_seen_R4: assert (|evti_o);
  end
endmodule

// File: rtl/spi_packer.sv
module spi_packer
  import irq_evt_pkg::*;
(
  input  logic [BOARD_LINES-1:0] board_spi_i,
  input  logic                   lcd_irq_i,
  input  logic [1:0]             smem_irq_i,
  input  logic                   dma_abort_i,
  input  logic [1:0]             dma_irq_i,
  input  logic [1:0]             core_npmu_i,
  input  logic [1:0]             comm_rx_i,
  input  logic [1:0]             comm_tx_i,
  output logic [SPI_W-1:0]       spi_vec_o
);
  always_comb begin
    spi_vec_o = '0;
    spi_vec_o[BOARD_LINES-1:0] = board_spi_i;
    spi_vec_o[POS_LCD]    = lcd_irq_i;
    spi_vec_o[POS_SMEM0]  = smem_irq_i[0];
    spi_vec_o[POS_SMEM1]  = smem_irq_i[1];
    spi_vec_o[POS_DMA_AB] = dma_abort_i;
    spi_vec_o[POS_DMA0]   = dma_irq_i[0];
    spi_vec_o[POS_DMA1]   = dma_irq_i[1];
    spi_vec_o[POS_PMU0]   = ~core_npmu_i[0];
    spi_vec_o[POS_PMU1]   = ~core_npmu_i[1];
    spi_vec_o[POS_COMM+0] = comm_rx_i[0];
    spi_vec_o[POS_COMM+1] = comm_rx_i[1];
    spi_vec_o[POS_COMM+2] = comm_tx_i[0];
    spi_vec_o[POS_COMM+3] = comm_tx_i[1];
  end

  always_comb begin
    assert_reserved_clear_R8: assert ((spi_vec_o & ~SPI_USED) == '0);
  end
endmodule

// File: rtl/dual_core_int_glue.sv
module dual_core_int_glue
  import irq_evt_pkg::*;
(
  input  logic                   board_nirq_i,
  input  logic                   board_nfiq_i,
  input  logic                   sw_irq_i,
  input  logic                   sw_fiq_i,
  input  logic [N_VEC-1:0]       vec_nirq_i,
  input  logic [N_VEC-1:0]       vec_nfiq_i,
  input  logic [N_CORES-1:0]     core_evto_i,
  input  logic                   board_evt_i,
  input  logic                   sl_wake_i,
  input  logic [BOARD_LINES-1:0] board_spi_i,
  input  logic                   lcd_irq_i,
  input  logic [1:0]             smem_irq_i,
  input  logic                   dma_abort_i,
  input  logic [1:0]             dma_irq_i,
  input  logic [1:0]             core_npmu_i,
  input  logic [1:0]             comm_rx_i,
  input  logic [1:0]             comm_tx_i,
  output logic [N_CORES-1:0]     core_nirq_o,
  output logic [N_CORES-1:0]     core_nfiq_o,
  output logic [N_CORES-1:0]     core_evti_o,
  output logic                   board_evt_o,
  output logic [SPI_W-1:0]       spi_vec_o
);
  for (genvar c = 0; c < N_CORES; c++) begin : g_core_int
    int_line_merge #(.NVEC(N_VEC)) u_irq (
      .board_n_i (board_nirq_i),
      .sw_force_i(sw_irq_i),
      .vec_n_i   (vec_nirq_i),
      .line_n_o  (core_nirq_o[c])
    );
    int_line_merge #(.NVEC(N_VEC)) u_fiq (
      .board_n_i (board_nfiq_i),
      .sw_force_i(sw_fiq_i),
      .vec_n_i   (vec_nfiq_i),
      .line_n_o  (core_nfiq_o[c])
    );
  end

  event_xlink #(.NCORE(N_CORES)) u_evt (
    .board_evt_i(board_evt_i),
    .wake_i     (sl_wake_i),
    .evto_i     (core_evto_i),
    .evti_o     (core_evti_o),
    .board_evt_o(board_evt_o)
  );

  spi_packer u_spi (
    .board_spi_i(board_spi_i),
    .lcd_irq_i  (lcd_irq_i),
    .smem_irq_i (smem_irq_i),
    .dma_abort_i(dma_abort_i),
    .dma_irq_i  (dma_irq_i),
    .core_npmu_i(core_npmu_i),
    .comm_rx_i  (comm_rx_i),
    .comm_tx_i  (comm_tx_i),
    .spi_vec_o  (spi_vec_o)
  );

  always_comb begin
    assert_cores_irq_agree_R1: assert (core_nirq_o == {N_CORES{core_nirq_o[0]}});
    assert_cores_fiq_agree_R2: assert (core_nfiq_o == {N_CORES{core_nfiq_o[0]}});
  end
endmodule

// File: tb/dual_core_int_glue_bench.sv
module dual_core_int_glue_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic board_nirq = 1'b1, board_nfiq = 1'b1, sw_irq = 1'b0, sw_fiq = 1'b0;
  logic [1:0] vec_nirq = 2'b11, vec_nfiq = 2'b11, evto = 2'b00;
  logic board_evt = 1'b0, wake = 1'b0;
  logic [42:0] bspi = '0;
  logic lcd = 1'b0, dab = 1'b0;
  logic [1:0] smem = '0, dma = '0, npmu = 2'b11, crx = '0, ctx = '0;
  logic [1:0] nirq, nfiq, evti;
  logic bevt;
  logic [127:0] spi;

  int checks = 0;
  int errors = 0;

  dual_core_int_glue u_dual_core_int_glue (
    .board_nirq_i(board_nirq), .board_nfiq_i(board_nfiq),
    .sw_irq_i(sw_irq), .sw_fiq_i(sw_fiq),
    .vec_nirq_i(vec_nirq), .vec_nfiq_i(vec_nfiq),
    .core_evto_i(evto), .board_evt_i(board_evt), .sl_wake_i(wake),
    .board_spi_i(bspi), .lcd_irq_i(lcd), .smem_irq_i(smem),
    .dma_abort_i(dab), .dma_irq_i(dma), .core_npmu_i(npmu),
    .comm_rx_i(crx), .comm_tx_i(ctx),
    .core_nirq_o(nirq), .core_nfiq_o(nfiq), .core_evti_o(evti),
    .board_evt_o(bevt), .spi_vec_o(spi)
  );

  function automatic logic [1:0] exp_line(logic b, logic f, logic [1:0] v);
    logic x;
    x = b & ~f & v[0] & v[1];
    return {x, x};
  endfunction

  function automatic logic [1:0] exp_evti();
    return {board_evt | evto[0] | wake, board_evt | evto[1] | wake};
  endfunction

  function automatic logic [127:0] exp_spi();
    logic [127:0] s;
    s = '0;
    s[42:0] = bspi;
    s[44] = lcd; s[45] = smem[0]; s[46] = smem[1];
    s[52] = dab; s[54] = dma[0]; s[55] = dma[1];
    s[60] = ~npmu[0]; s[61] = ~npmu[1];
    s[64] = crx[0]; s[65] = crx[1]; s[66] = ctx[0]; s[67] = ctx[1];
    return s;
  endfunction

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [127:0] e;
    #1;
    chk("R1", 128'(nirq), 128'(exp_line(board_nirq, sw_irq, vec_nirq)));
    chk("R2", 128'(nfiq), 128'(exp_line(board_nfiq, sw_fiq, vec_nfiq)));
    chk("R3", 128'(evti), 128'(exp_evti()));
    chk("R4", 128'(bevt), 128'(evto[0] | evto[1]));
    e = exp_spi();
    chk("R5", 128'(spi[42:0]), 128'(e[42:0]));
    chk("R6", 128'({spi[55:52], spi[46:44]}), 128'({e[55:52], e[46:44]}));
    chk("R7", 128'({spi[67:64], spi[61:60]}), 128'({e[67:64], e[61:60]}));
    chk("R8", spi & ~irq_evt_pkg::SPI_USED, 128'd0);
  endtask

  task automatic randomize_inputs();
    board_nirq = 1'($urandom); board_nfiq = 1'($urandom);
    sw_irq = (($urandom % 4) == 0); sw_fiq = (($urandom % 4) == 0);
    vec_nirq = 2'($urandom | $urandom); vec_nfiq = 2'($urandom | $urandom);
    evto = 2'($urandom); board_evt = (($urandom % 3) == 0); wake = (($urandom % 3) == 0);
    bspi = {11'($urandom), 32'($urandom)};
    lcd = 1'($urandom); dab = 1'($urandom);
    smem = 2'($urandom); dma = 2'($urandom); npmu = 2'($urandom);
    crx = 2'($urandom); ctx = 2'($urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // idle state: no interrupts, no events, PMU inactive (high) gives zero vector
    check_all();
    chk("R8", spi, 128'd0);
    // R1: software force alone pulls IRQ low on both cores
    sw_irq = 1'b1; check_all(); chk("R1", 128'(nirq), 128'd0);
    sw_irq = 1'b0; vec_nirq = 2'b10; check_all(); chk("R1", 128'(nirq), 128'd0);
    vec_nirq = 2'b11; board_nfiq = 1'b0; check_all(); chk("R2", 128'(nfiq), 128'd0);
    board_nfiq = 1'b1; vec_nfiq = 2'b01; check_all();
    vec_nfiq = 2'b11;
    // R3: own event does not loop back
    evto = 2'b01; check_all(); chk("R3", 128'(evti), 128'(2'b10));
    evto = 2'b10; check_all(); chk("R3", 128'(evti), 128'(2'b01));
    evto = 2'b00; wake = 1'b1; check_all(); chk("R3", 128'(evti), 128'(2'b11));
    wake = 1'b0; board_evt = 1'b1; check_all();
    board_evt = 1'b0;
    // R7: PMU inverted positions
    npmu = 2'b00; check_all(); chk("R7", 128'(spi[61:60]), 128'(2'b11));
    npmu = 2'b11;
    // R5 R6 R8: all sources high, reserved still clear
    bspi = '1; lcd = 1'b1; smem = '1; dab = 1'b1; dma = '1; crx = '1; ctx = '1;
    check_all();
    // R9: changes seen without waiting for a clock edge
    repeat (400) begin
      randomize_inputs();
      check_all();
      #(CLK_PERIOD/3);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule